// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called A and B, each `WIDTH` bits wide. Each transfer direction has its own storage register. The A-to-B register takes a snapshot of bus A when its capture strobe rises. The B-to-A register takes a snapshot of bus B when its own strobe rises. A per-direction select sets what the driven side carries: the live value of the opposite bus, or that direction's stored snapshot. An active-low enable and a direction input decide which side is driven, if either.

The pads are split into separate input, output and output-enable signals for each bus, so that the tri-state buffers can sit in the pad ring. Everything runs on one system clock. The capture strobes are sampled on that clock and edge-detected. The output data and enables come from registers, so a change of select cannot produce a transient decode value.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While `rstN` is low at a clock edge, both storage registers, both data outputs and both output enables are cleared to zero.
- R2: When `capAb` is seen high at a clock edge after being low at the previous edge, the A-to-B register loads `aIn` at that edge. Holding `capAb` high causes no further loads.
- R3: When `capBa` is seen high at a clock edge after being low at the previous edge, the B-to-A register loads `bIn` at that edge. Holding `capBa` high causes no further loads.
- R4: A load happens whatever the values of `enN`, `dirAtoB`, `selAb` and `selBa`.
- R5: With `selAb` low, `bOut` shows the `aIn` value sampled at the previous clock edge. With `selBa` low, `aOut` shows the `bIn` value sampled at the previous clock edge.
- R6: With `selAb` high, `bOut` shows the A-to-B register as it stood before the previous edge. With `selBa` high, `aOut` does the same for the B-to-A register.
- R7: When `enN` is high at a clock edge, `aOe` and `bOe` are both low after that edge.
- R8: When `enN` is low at a clock edge, `bOe` is high and `aOe` is low after that edge if `dirAtoB` is 1. If `dirAtoB` is 0, `aOe` is high and `bOe` is low.
- R9: When the live data equals the stored data, toggling the select leaves the output at that value in every cycle.
- R10: A load into one direction's register never changes the other direction's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| aIn | input | WIDTH | Value received from bus A |
| aOut | output | WIDTH | Value to drive onto bus A |
| aOe | output | 1 | Drive enable for bus A |
| bIn | input | WIDTH | Value received from bus B |
| bOut | output | WIDTH | Value to drive onto bus B |
| bOe | output | 1 | Drive enable for bus B |
| capAb | input | 1 | Capture strobe, A-to-B register |
| capBa | input | 1 | Capture strobe, B-to-A register |
| selAb | input | 1 | 1: bus B gets stored data, 0: live A |
| selBa | input | 1 | 1: bus A gets stored data, 0: live B |
| enN | input | 1 | Output enable, active low |
| dirAtoB | input | 1 | 1: drive bus B, 0: drive bus A |

## Verification
The bench builds the block with the default `WIDTH` of 8. At that width, full-scale patterns such as all ones, all zeros and single walking bits can be applied on both buses. Random byte values also make it unlikely that a swapped or stale source happens to match the expected value. A cycle model kept in the bench tracks both stored snapshots and the strobe history. This lets the random phase mix strobe edges, held strobes, select flips and enable/direction changes in any order.

// File: rtl/reg_bus_xcvr_pkg.sv
package reg_bus_xcvr_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic ldAb;         // single-cycle load of the A-to-B register
    logic ldBa;         // single-cycle load of the B-to-A register
    logic useStoredAb;  // bus B gets the stored value
    logic useStoredBa;  // bus A gets the stored value
    logic driveA;       // bus A output enabled
    logic driveB;       // bus B output enabled
  } xfer_strobe_t;
endpackage

// File: rtl/reg_bus_xcvr_ctrl.sv
module reg_bus_xcvr_ctrl
  import reg_bus_xcvr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         capAb,
  input  logic         capBa,
  input  logic         selAb,
  input  logic         selBa,
  input  logic         enN,
  input  logic         dirAtoB,
  output xfer_strobe_t strb
);
  logic capAbQ;
  logic capBaQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAbQ <= 1'b0;
      capBaQ <= 1'b0;
    end else begin
      capAbQ <= capAb;
      capBaQ <= capBa;
    end
  end

  always_comb begin
    strb             = '0;
    strb.ldAb        = capAb & ~capAbQ;
    strb.ldBa        = capBa & ~capBaQ;
    strb.useStoredAb = selAb;
    strb.useStoredBa = selBa;
    strb.driveB      = ~enN & dirAtoB;
    strb.driveA      = ~enN & ~dirAtoB;
  end

  // A held strobe yields no second load
  AST_HELD_NO_RELOAD_AB: assert property (@(posedge clk) disable iff (!rstN)
    (capAb && $past(capAb)) |-> !strb.ldAb) else $error("held capAb reloaded"); // R2
  AST_HELD_NO_RELOAD_BA: assert property (@(posedge clk) disable iff (!rstN)
    (capBa && $past(capBa)) |-> !strb.ldBa) else $error("held capBa reloaded"); // R3
endmodule

// File: rtl/reg_bus_xcvr_path.sv
module reg_bus_xcvr_path
  import reg_bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  xfer_strobe_t     strb,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut,
  output logic             aOe,
  output logic             bOe
);
  logic [WIDTH-1:0] regAb;
  logic [WIDTH-1:0] regBa;

  // Storage registers: loads follow only the load strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAb <= '0;
      regBa <= '0;
    end else begin
      if (strb.ldAb) regAb <= aIn;
      if (strb.ldBa) regBa <= bIn;
    end
  end

  // Registered source select and drive enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aOut <= '0;
      bOut <= '0;
      aOe  <= 1'b0;
      bOe  <= 1'b0;
    end else begin
      bOut <= strb.useStoredAb ? regAb : aIn;
      aOut <= strb.useStoredBa ? regBa : bIn;
      aOe  <= strb.driveA;
      bOe  <= strb.driveB;
    end
  end

  AST_LOAD_AB: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldAb |=> (regAb == $past(aIn))) else $error("A-to-B load lost"); // R2
  AST_LOAD_BA: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldBa |=> (regBa == $past(bIn))) else $error("B-to-A load lost"); // R3
  AST_KEEP_AB: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldAb |=> $stable(regAb)) else $error("A-to-B register disturbed"); // R10
  AST_KEEP_BA: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldBa |=> $stable(regBa)) else $error("B-to-A register disturbed"); // R10
  AST_NO_GLITCH_AB: assert property (@(posedge clk) disable iff (!rstN)
    (aIn == regAb && !strb.ldAb) |=> (bOut == $past(aIn))) else $error("select glitch on B"); // R9
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import reg_bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe,
  input  logic             capAb,
  input  logic             capBa,
  input  logic             selAb,
  input  logic             selBa,
  input  logic             enN,
  input  logic             dirAtoB
);
  xfer_strobe_t strb;

  reg_bus_xcvr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .capAb   (capAb),
    .capBa   (capBa),
    .selAb   (selAb),
    .selBa   (selBa),
    .enN     (enN),
    .dirAtoB (dirAtoB),
    .strb    (strb)
  );

  reg_bus_xcvr_path #(.WIDTH(WIDTH)) u_path (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .aIn  (aIn),
    .bIn  (bIn),
    .aOut (aOut),
    .bOut (bOut),
    .aOe  (aOe),
    .bOe  (bOe)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    enN |=> (!aOe && !bOe)) else $error("output enabled while disabled"); // R7
  AST_DIR_TO_B: assert property (@(posedge clk) disable iff (!rstN)
    (!enN && dirAtoB) |=> (bOe && !aOe)) else $error("wrong side driven"); // R8
  AST_DIR_TO_A: assert property (@(posedge clk) disable iff (!rstN)
    (!enN && !dirAtoB) |=> (aOe && !bOe)) else $error("wrong side driven"); // R8
endmodule

// File: tb/reg_bus_xcvr_bench.sv
module reg_bus_xcvr_bench;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rstN;
  logic [WIDTH-1:0] aIn, bIn, aOut, bOut;
  logic aOe, bOe, capAb, capBa, selAb, selBa, enN, dirAtoB;

  always #2.5 clk = ~clk;

  reg_bus_xcvr #(.WIDTH(WIDTH)) u_reg_bus_xcvr (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe), .capAb(capAb), .capBa(capBa),
    .selAb(selAb), .selBa(selBa), .enN(enN), .dirAtoB(dirAtoB)
  );

  // Bench model, built from the requirements
  logic [WIDTH-1:0] mAb, mBa, eAOut, eBOut;
  logic mCapAbQ, mCapBaQ, eAOe, eBOe;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // Inputs change at the falling edge; one rising edge; sample at the next falling edge
  task automatic tick();
    @(posedge clk);
    #0.1;
    if (!rstN) begin
      mAb = '0; mBa = '0; eAOut = '0; eBOut = '0;
      eAOe = 0; eBOe = 0; mCapAbQ = 0; mCapBaQ = 0;
    end else begin
      eBOut = selAb ? mAb : aIn;
      eAOut = selBa ? mBa : bIn;
      eBOe  = !enN && dirAtoB;
      eAOe  = !enN && !dirAtoB;
      if (capAb && !mCapAbQ) mAb = aIn;
      if (capBa && !mCapBaQ) mBa = bIn;
      mCapAbQ = capAb;
      mCapBaQ = capBa;
    end
    @(negedge clk);
  endtask

  task automatic check(input string tag);
    nChecks++;
    if (aOut !== eAOut || bOut !== eBOut || aOe !== eAOe || bOe !== eBOe) begin
      nFails++;
      $display("FAIL %s: aOut=%h bOut=%h aOe=%b bOe=%b, expected aOut=%h bOut=%h aOe=%b bOe=%b",
               tag, aOut, bOut, aOe, bOe, eAOut, eBOut, eAOe, eBOe);
    end
  endtask

  task automatic checkVal(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    capAb = 0; capBa = 0; selAb = 0; selBa = 0; enN = 1; dirAtoB = 0;
    aIn = '0; bIn = '0;
  endtask

  task automatic test_reset();
    rstN = 0; idle(); aIn = 8'hA5; bIn = 8'h5A; enN = 0; selAb = 1; selBa = 1;
    tick(); tick();
    checkVal("R1 bOut", bOut, '0);
    checkVal("R1 aOut", aOut, '0);
    check("R1");
    rstN = 1; selAb = 1; selBa = 1; enN = 1;
    tick();
    checkVal("R1 stored AB", bOut, '0);
    checkVal("R1 stored BA", aOut, '0);
  endtask

  task automatic test_live();
    selAb = 0; selBa = 0;
    aIn = 8'h3C; bIn = 8'hC3; tick();
    checkVal("R5 bOut", bOut, 8'h3C); checkVal("R5 aOut", aOut, 8'hC3);
    aIn = 8'hFF; bIn = 8'h00; tick(); check("R5");
    for (int i = 0; i < WIDTH; i++) begin
      aIn = 8'(1 << i); bIn = ~aIn; tick(); check("R5 walk");
    end
  endtask

  task automatic test_capture_a();
    selAb = 1; aIn = 8'h96; capAb = 1; tick();
    aIn = 8'h11; tick();               // strobe held high
    checkVal("R2 capture", bOut, 8'h96);
    aIn = 8'h22; tick();
    checkVal("R2 held no reload", bOut, 8'h96);
    capAb = 0; tick(); check("R6");
  endtask

  task automatic test_capture_b();
    selBa = 1; bIn = 8'h69; capBa = 1; tick();
    bIn = 8'h33; tick();
    checkVal("R3 capture", aOut, 8'h69);
    bIn = 8'h44; tick();
    checkVal("R3 held no reload", aOut, 8'h69);
    capBa = 0; tick(); check("R6");
  endtask

  task automatic test_capture_ignores_controls();
    selAb = 0; selBa = 0; enN = 1; dirAtoB = 0;
    aIn = 8'hE7; bIn = 8'h7E; capAb = 1; capBa = 1; tick();
    capAb = 0; capBa = 0; aIn = 8'h00; bIn = 8'h00; enN = 0; dirAtoB = 1; tick();
    selAb = 1; selBa = 1; tick(); tick();
    checkVal("R4 AB stored", bOut, 8'hE7);
    checkVal("R4 BA stored", aOut, 8'h7E);
    check("R4");
  endtask

  task automatic test_enable();
    enN = 1; dirAtoB = 1; tick(); check("R7");
    dirAtoB = 0; tick(); check("R7");
    enN = 0; dirAtoB = 1; tick(); check("R8 to B");
    checkVal("R8 bOe", {7'b0, bOe}, 8'd1);
    dirAtoB = 0; tick(); check("R8 to A");
    checkVal("R8 aOe", {7'b0, aOe}, 8'd1);
  endtask

  task automatic test_glitch();
    // stored AB is E7; make live A equal and toggle the select
    aIn = 8'hE7;
    for (int i = 0; i < 8; i++) begin
      selAb = ~selAb; tick();
      checkVal("R9 no glitch", bOut, 8'hE7);
    end
  endtask

  task automatic test_independent();
    selAb = 1; selBa = 1;
    aIn = 8'h5C; capAb = 1; tick(); capAb = 0; tick();
    checkVal("R10 BA untouched", aOut, 8'h7E);
    checkVal("R10 AB loaded", bOut, 8'h5C);
    bIn = 8'hC5; capBa = 1; tick(); capBa = 0; tick();
    checkVal("R10 AB untouched", bOut, 8'h5C);
    check("R10");
  endtask

  task automatic test_random();
    for (int i = 0; i < 400; i++) begin
      aIn = 8'($urandom); bIn = 8'($urandom);
      capAb = 1'($urandom); capBa = 1'($urandom);
      selAb = 1'($urandom); selBa = 1'($urandom);
      enN = 1'($urandom); dirAtoB = 1'($urandom);
      tick(); check("R2 R3 R5 R6 R8 random");
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    rstN = 0; idle();
    @(negedge clk);
    test_reset();
    test_live();
    test_capture_a();
    test_capture_b();
    test_capture_ignores_controls();
    test_enable();
    test_glitch();
    test_independent();
    test_random();
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end
endmodule